// File: doc/BRIEF.md
# Scalar Branch Next-PC Unit

This block sits in the scalar front end of a compute core. It decodes one 32-bit program-flow instruction word and works out which address runs next. The inputs that matter are the word itself, a scalar condition bit and two 64-bit lane masks: the vector condition mask and the execution mask. The block keeps its own program-counter register. On every cycle where the instruction strobe is high, that register moves to the computed next address.

A branch target is the address of the following instruction (PC + 4) plus the sign-extended 16-bit immediate, wrapped to the PC width. One opcode branches unconditionally. Six more opcodes branch on one of three tests: the scalar bit being clear or set, the condition mask being all zero or not, and the execution mask being all zero or not. Every other opcode falls through to PC + 4. So does a word whose encoding field is wrong, and such a word also raises a flag. A synchronous reset loads the PC from a start-address input.

The decision is combinational within the strobe cycle. `next_pc`, `taken` and `illegal` describe the word that is present now, and `pc_q` shows the result after the clock edge.

Top module: `sbr_nextpc`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_q` takes the value of `start_addr`. This holds even if `insn_valid` is high in that cycle.
- R2: With `insn_valid` low, `next_pc` equals `pc_q`, `taken` and `illegal` are low, and `pc_q` holds its value across the edge.
- R3: With `insn_valid` high and bits 31:23 of `insn` different from binary 101111110, `illegal` is high, `taken` is low and `next_pc` is `pc_q + 4`, whatever the opcode.
- R4: For a legal word with opcode 2 (bits 22:16), `taken` is high and `next_pc` is `pc_q + 4 + sign_extend(insn[15:0])`.
- R5: Opcode 4 branches when `scc` is 0 and opcode 5 branches when `scc` is 1. When the condition fails, `next_pc` is `pc_q + 4` and `taken` is low.
- R6: Opcode 6 branches when `vcc` is all zero and opcode 7 branches when any bit of `vcc` is set. When the condition fails, the result is `pc_q + 4`.
- R7: Opcode 8 branches when `exec_mask` is all zero and opcode 9 branches when any bit of `exec_mask` is set. When the condition fails, the result is `pc_q + 4`.
- R8: Any other opcode in a legal word gives `next_pc = pc_q + 4` with `taken` and `illegal` both low.
- R9: Both the PC + 4 step and the target addition wrap modulo 2^PCW.
- R10: After a clock edge where `insn_valid` was high and `rst` low, `pc_q` equals the `next_pc` shown in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_addr | input | PCW | Address loaded into the PC on reset |
| insn_valid | input | 1 | Instruction strobe; the PC advances on cycles where it is high |
| insn | input | 32 | Instruction word |
| scc | input | 1 | Scalar condition bit |
| vcc | input | MASKW | Vector condition mask |
| exec_mask | input | MASKW | Execution mask |
| pc_q | output | PCW | Current program counter |
| next_pc | output | PCW | Address of the next instruction |
| taken | output | 1 | The branch target was selected this cycle |
| illegal | output | 1 | The encoding field of the strobed word is wrong |

## Verification
Two functions can fall in the same cycle.

The first pair is the encoding check and the branch decision. The bench strobes a word that carries the unconditional-branch opcode with a corrupted encoding field. It then expects `illegal` high, `taken` low and a plain PC + 4 step, so the encoding check must override the branch.

The second pair is reset and the strobe. The bench raises `rst` in the same cycle as a strobed, taken branch. It then expects `pc_q` to equal the start address and not the branch target.

Masks with only the top bit set, and a start address near the top of the address space, confirm the full-width zero tests and the wrap-around.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int INSN_W  = 32;
    localparam int IMM_W   = 16;
    localparam int OPC_W   = 7;
    localparam int ENC_W   = 9;
    localparam int OPC_LSB = IMM_W;
    localparam int ENC_LSB = IMM_W + OPC_W;
    localparam int STEP    = 4;

    localparam logic [ENC_W-1:0] ENC_FLOW = 9'b101111110;

    localparam logic [OPC_W-1:0] OP_JUMP      = 7'd2;
    localparam logic [OPC_W-1:0] OP_SCALAR_LO = 7'd4;
    localparam logic [OPC_W-1:0] OP_SCALAR_HI = 7'd5;
    localparam logic [OPC_W-1:0] OP_VCOND_Z   = 7'd6;
    localparam logic [OPC_W-1:0] OP_VCOND_NZ  = 7'd7;
    localparam logic [OPC_W-1:0] OP_LANES_Z   = 7'd8;
    localparam logic [OPC_W-1:0] OP_LANES_NZ  = 7'd9;

    typedef enum logic [2:0] {
        CND_NONE,
        CND_ALWAYS,
        CND_SCALAR_LO,
        CND_SCALAR_HI,
        CND_VCOND_Z,
        CND_VCOND_NZ,
        CND_LANES_Z,
        CND_LANES_NZ
    } cond_e;

endpackage

// File: rtl/sbr_decode.sv
module sbr_decode
    import sbr_pkg::*;
(
    input  logic [INSN_W-1:0] insn,
    output logic              legal,
    output cond_e             cond,
    output logic [IMM_W-1:0]  imm
);
    logic [OPC_W-1:0] opc;
    logic [ENC_W-1:0] enc;

    always_comb begin
        imm   = insn[IMM_W-1:0];
        opc   = insn[OPC_LSB +: OPC_W];
        enc   = insn[ENC_LSB +: ENC_W];
        legal = (enc == ENC_FLOW);
        unique case (opc)
            OP_JUMP:      cond = CND_ALWAYS;
            OP_SCALAR_LO: cond = CND_SCALAR_LO;
            OP_SCALAR_HI: cond = CND_SCALAR_HI;
            OP_VCOND_Z:   cond = CND_VCOND_Z;
            OP_VCOND_NZ:  cond = CND_VCOND_NZ;
            OP_LANES_Z:   cond = CND_LANES_Z;
            OP_LANES_NZ:  cond = CND_LANES_NZ;
            default:      cond = CND_NONE;
        endcase
    end
endmodule

// File: rtl/sbr_cond_eval.sv
module sbr_cond_eval
    import sbr_pkg::*;
#(
    parameter int MASKW = 64
) (
    input  cond_e             cond,
    input  logic              scc,
    input  logic [MASKW-1:0]  vcc,
    input  logic [MASKW-1:0]  exec_mask,
    output logic              hit
);
    logic vcc_any;
    logic exec_any;

    always_comb begin
        vcc_any  = |vcc;
        exec_any = |exec_mask;
        unique case (cond)
            CND_ALWAYS:    hit = 1'b1;
            CND_SCALAR_LO: hit = !scc;
            CND_SCALAR_HI: hit = scc;
            CND_VCOND_Z:   hit = !vcc_any;
            CND_VCOND_NZ:  hit = vcc_any;
            CND_LANES_Z:   hit = !exec_any;
            CND_LANES_NZ:  hit = exec_any;
            default:       hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/sbr_target.sv
module sbr_target
    import sbr_pkg::*;
#(
    parameter int PCW = 48
) (
    input  logic [PCW-1:0]   pc,
    input  logic [IMM_W-1:0] imm,
    output logic [PCW-1:0]   seq_pc,
    output logic [PCW-1:0]   tgt_pc
);
    localparam int EXT_W = PCW - IMM_W;

    logic [PCW-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        seq_pc  = pc + PCW'(STEP);
        tgt_pc  = seq_pc + imm_ext;
    end
endmodule

// File: rtl/sbr_nextpc.sv
module sbr_nextpc
    import sbr_pkg::*;
#(
    parameter int PCW   = 48,
    parameter int MASKW = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PCW-1:0]    start_addr,
    input  logic              insn_valid,
    input  logic [INSN_W-1:0] insn,
    input  logic              scc,
    input  logic [MASKW-1:0]  vcc,
    input  logic [MASKW-1:0]  exec_mask,
    output logic [PCW-1:0]    pc_q,
    output logic [PCW-1:0]    next_pc,
    output logic              taken,
    output logic              illegal
);
    logic             legal;
    cond_e            cond;
    logic [IMM_W-1:0] imm;
    logic             hit;
    logic [PCW-1:0]   seq_pc;
    logic [PCW-1:0]   tgt_pc;

    sbr_decode u_dec (
        .insn  (insn),
        .legal (legal),
        .cond  (cond),
        .imm   (imm)
    );

    sbr_cond_eval #(.MASKW(MASKW)) u_cond (
        .cond      (cond),
        .scc       (scc),
        .vcc       (vcc),
        .exec_mask (exec_mask),
        .hit       (hit)
    );

    sbr_target #(.PCW(PCW)) u_tgt (
        .pc     (pc_q),
        .imm    (imm),
        .seq_pc (seq_pc),
        .tgt_pc (tgt_pc)
    );

    always_comb begin
        next_pc = pc_q;
        taken   = 1'b0;
        illegal = 1'b0;
        if (insn_valid) begin
            if (!legal) begin
                illegal = 1'b1;
                next_pc = seq_pc;
            end else begin
                taken   = hit;
                next_pc = hit ? tgt_pc : seq_pc;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= start_addr;
        end else if (insn_valid) begin
            pc_q <= next_pc;
        end
    end
endmodule

// File: rtl/sbr_nextpc_chk.sv
module sbr_nextpc_chk
    import sbr_pkg::*;
#(
    parameter int PCW   = 48,
    parameter int MASKW = 64
) (
    input logic              clk,
    input logic              rst,
    input logic [PCW-1:0]    start_addr,
    input logic              insn_valid,
    input logic [INSN_W-1:0] insn,
    input logic              scc,
    input logic [MASKW-1:0]  vcc,
    input logic [MASKW-1:0]  exec_mask,
    input logic [PCW-1:0]    pc_q,
    input logic [PCW-1:0]    next_pc,
    input logic              taken,
    input logic              illegal
);
    logic good_word;
    logic [OPC_W-1:0] opc;
    assign good_word = insn_valid && (insn[ENC_LSB +: ENC_W] == ENC_FLOW);
    assign opc       = insn[OPC_LSB +: OPC_W];

    // R1
    a_r1_reset_load: assert property (@(posedge clk)
        rst |=> pc_q == $past(start_addr));

    // R2
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !insn_valid |-> (next_pc == pc_q) && !taken && !illegal);

    // R3
    a_r3_bad_word: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !good_word) |-> illegal && !taken && (next_pc == pc_q + PCW'(STEP)));

    // R4
    a_r4_jump_taken: assert property (@(posedge clk) disable iff (rst)
        (good_word && opc == OP_JUMP) |-> taken && !illegal);

    // R5
    a_r5_scalar: assert property (@(posedge clk) disable iff (rst)
        (good_word && (opc == OP_SCALAR_LO || opc == OP_SCALAR_HI))
            |-> taken == (scc == opc[0]));

    // R6
    a_r6_vcond: assert property (@(posedge clk) disable iff (rst)
        (good_word && (opc == OP_VCOND_Z || opc == OP_VCOND_NZ))
            |-> taken == ((vcc != '0) == opc[0]));

    // R7
    a_r7_lanes: assert property (@(posedge clk) disable iff (rst)
        (good_word && (opc == OP_LANES_Z || opc == OP_LANES_NZ))
            |-> taken == ((exec_mask != '0) == opc[0]));

    // R8
    a_r8_not_taken_step: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !taken) |-> next_pc == pc_q + PCW'(STEP));

    // R10
    a_r10_commit: assert property (@(posedge clk) disable iff (rst)
        (insn_valid && !rst) |=> pc_q == $past(next_pc));
endmodule

bind sbr_nextpc sbr_nextpc_chk #(.PCW(PCW), .MASKW(MASKW)) u_chk (.*);

// File: tb/sbr_nextpc_test.sv
module sbr_nextpc_test;
    localparam int PCW   = 48;
    localparam int MASKW = 64;

    typedef struct {
        logic [PCW-1:0] pc;
        logic [PCW-1:0] nxt;
        logic           tk;
        logic           il;
        string          tag;
    } item_t;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [PCW-1:0]    start_addr = '0;
    logic              insn_valid = 1'b0;
    logic [31:0]       insn = '0;
    logic              scc = 1'b0;
    logic [MASKW-1:0]  vcc = '0;
    logic [MASKW-1:0]  exec_mask = '0;
    logic [PCW-1:0]    pc_q;
    logic [PCW-1:0]    next_pc;
    logic              taken;
    logic              illegal;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    item_t sb[$];
    logic [PCW-1:0] model_pc;

    always #2 clk = ~clk;

    sbr_nextpc #(.PCW(PCW), .MASKW(MASKW)) uut (
        .clk(clk), .rst(rst), .start_addr(start_addr), .insn_valid(insn_valid),
        .insn(insn), .scc(scc), .vcc(vcc), .exec_mask(exec_mask),
        .pc_q(pc_q), .next_pc(next_pc), .taken(taken), .illegal(illegal)
    );

    function automatic logic [31:0] mk(input logic [8:0] enc, input logic [6:0] op,
                                       input logic [15:0] imm);
        return {enc, op, imm};
    endfunction

    // Model from the requirements.
    task automatic predict(input logic v, input logic [31:0] w, output logic [PCW-1:0] nx,
                           output logic tk, output logic il);
        logic [PCW-1:0] seq;
        logic [PCW-1:0] tgt;
        logic cnd;
        seq = model_pc + 48'd4;
        tgt = seq + {{(PCW-16){w[15]}}, w[15:0]};
        tk = 1'b0; il = 1'b0; nx = model_pc;
        if (v) begin
            if (w[31:23] != 9'b101111110) begin
                il = 1'b1; nx = seq;
            end else begin
                case (w[22:16])
                    7'd2:    cnd = 1'b1;
                    7'd4:    cnd = (scc == 1'b0);
                    7'd5:    cnd = (scc == 1'b1);
                    7'd6:    cnd = (vcc == '0);
                    7'd7:    cnd = (vcc != '0);
                    7'd8:    cnd = (exec_mask == '0);
                    7'd9:    cnd = (exec_mask != '0);
                    default: cnd = 1'b0;
                endcase
                tk = cnd;
                nx = cnd ? tgt : seq;
            end
        end
    endtask

    task automatic step(input logic v, input logic [31:0] w, input logic s,
                        input logic [MASKW-1:0] vm, input logic [MASKW-1:0] em,
                        input string tag);
        item_t it;
        @(negedge clk);
        rst = 1'b0; insn_valid = v; insn = w; scc = s; vcc = vm; exec_mask = em;
        it.pc = model_pc;
        predict(v, w, it.nxt, it.tk, it.il);
        it.tag = tag;
        sb.push_back(it);
        if (v) model_pc = it.nxt;
    endtask

    task automatic do_reset(input logic [PCW-1:0] sa, input logic v, input logic [31:0] w);
        @(negedge clk);
        rst = 1'b1; start_addr = sa; insn_valid = v; insn = w; scc = 1'b0;
        vcc = '0; exec_mask = '0;
        model_pc = sa;
    endtask

    task automatic cmp(input logic [PCW-1:0] act, input logic [PCW-1:0] exp, input string req,
                       input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Monitor: compares each cycle's outputs against the head of the queue.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                cmp(pc_q, it.pc, (it.tag == "R1") ? "R1" : "R10", "pc_q");
                cmp(next_pc, it.nxt, it.tag, "next_pc");
                cmp({47'd0, taken}, {47'd0, it.tk}, it.tag, "taken");
                cmp({47'd0, illegal}, {47'd0, it.il}, it.tag, "illegal");
            end
        end
    end

    localparam logic [8:0] ENC = 9'b101111110;
    localparam logic [MASKW-1:0] TOP = {1'b1, {(MASKW-1){1'b0}}};

    initial begin
        do_reset(48'h0000_1000_0000, 1'b0, '0);
        step(1'b0, '0, 1'b0, '0, '0, "R1");                          // reset state
        step(1'b0, mk(ENC, 7'd2, 16'h0100), 1'b0, '0, '0, "R2");     // strobe low
        step(1'b1, mk(ENC, 7'd2, 16'h0010), 1'b0, '0, '0, "R4");     // forward jump
        step(1'b1, mk(ENC, 7'd2, 16'hFFF0), 1'b0, '0, '0, "R4");     // backward jump
        step(1'b1, mk(ENC, 7'd4, 16'h0020), 1'b0, '0, '0, "R5");
        step(1'b1, mk(ENC, 7'd4, 16'h0020), 1'b1, '0, '0, "R5");
        step(1'b1, mk(ENC, 7'd5, 16'h0040), 1'b1, '0, '0, "R5");
        step(1'b1, mk(ENC, 7'd5, 16'h0040), 1'b0, '0, '0, "R5");
        step(1'b1, mk(ENC, 7'd6, 16'h0008), 1'b0, '0, '0, "R6");
        step(1'b1, mk(ENC, 7'd6, 16'h0008), 1'b0, TOP, '0, "R6");
        step(1'b1, mk(ENC, 7'd7, 16'hFF00), 1'b0, TOP, '0, "R6");
        step(1'b1, mk(ENC, 7'd7, 16'hFF00), 1'b0, '0, '0, "R6");
        step(1'b1, mk(ENC, 7'd8, 16'h0030), 1'b0, '0, '0, "R7");
        step(1'b1, mk(ENC, 7'd8, 16'h0030), 1'b0, '0, TOP, "R7");
        step(1'b1, mk(ENC, 7'd9, 16'h8000), 1'b0, '0, 64'h1, "R7");
        step(1'b1, mk(ENC, 7'd9, 16'h8000), 1'b0, '0, '0, "R7");
        step(1'b1, mk(9'b101111111, 7'd2, 16'h0100), 1'b0, '0, '0, "R3"); // bad encoding + jump
        step(1'b1, mk(9'b001111110, 7'd5, 16'h0100), 1'b1, '0, '0, "R3");
        step(1'b1, mk(ENC, 7'd0, 16'h0100), 1'b1, TOP, TOP, "R8");
        step(1'b1, mk(ENC, 7'd12, 16'h0100), 1'b0, '0, '0, "R8");
        step(1'b1, mk(ENC, 7'd3, 16'h0100), 1'b0, '0, '0, "R8");
        step(1'b0, '0, 1'b0, '0, '0, "R2");
        // reset together with a taken strobe: reset wins
        do_reset(48'hFFFF_FFFF_FFFC, 1'b1, mk(ENC, 7'd2, 16'h0400));
        step(1'b0, '0, 1'b0, '0, '0, "R1");
        step(1'b1, mk(ENC, 7'd2, 16'h0008), 1'b0, '0, '0, "R9");     // wraps to 8
        do_reset(48'hFFFF_FFFF_FFF8, 1'b0, '0);
        step(1'b1, mk(ENC, 7'd12, 16'h0000), 1'b0, '0, '0, "R9");
        step(1'b1, mk(ENC, 7'd2, 16'h0004), 1'b0, '0, '0, "R9");    // 0xFFFC+4 -> 0 +4 = 4
        step(1'b1, mk(ENC, 7'd2, 16'hFFF8), 1'b0, '0, '0, "R9");    // 4+4-8 -> 0
        step(1'b0, '0, 1'b0, '0, '0, "R10");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule